// File: doc/BRIEF.md
# Real-Time Seconds Timer with Alarm

This block keeps elapsed time from a free-running slow clock of nominally 32.768 kHz. A programmable prescaler counts rising edges of the slow clock. Each time the prescaler wraps, a seconds counter steps by one. Software cannot load the counter. It can only restart both the counter and the prescaler from zero by writing a self-clearing command bit in the mode word. A compare against a programmable alarm value raises a sticky alarm flag. Every counter step raises a sticky step flag. Each flag can be routed to a single interrupt line by its own enable bit.

Software reaches four 32-bit words through a plain synchronous register port. Each transfer completes in one cycle, and read data appears registered on the following cycle. The port carries control and status only, so it has no handshake and never stalls.

The slow clock is treated as an asynchronous input. It is synchronised into the bus clock and turned into one step per rising edge. The counter therefore changes only in the bus domain. A driver that reads the value word twice and keeps only matching pairs also stays correct on a design where the counter lives in the slow domain.

Top module: `rtt_timer`

## Requirements
- R1: After reset the mode word reads with only prescaler bit PRESC_W-1 set (0x00008000 with the default 16-bit prescaler). The alarm word reads all ones. The value and status words read zero, and `irq_o` is low.
- R2: The words sit at word offsets 0 (mode), 1 (alarm), 2 (value) and 3 (status). Mode bits [PRESC_W-1:0] hold the prescaler, bit 16 enables the alarm interrupt and bit 17 enables the step interrupt; mode and alarm read back what was written.
- R3: The counter steps once every N rising edges of the slow clock, where N is the prescaler field, and a prescaler field of zero means N = 2^PRESC_W.
- R4: Writes to the value word (offset 2) and the status word (offset 3) change nothing.
- R5: Writing the mode word with bit 18 set clears the counter and the prescaler phase at once and also loads the new prescaler and enables; bit 18 always reads back as zero.
- R6: Status bit 1 (step flag) sets whenever the counter steps.
- R7: Status bit 0 (alarm flag) sets on the step in which the counter becomes equal to the alarm word; an alarm of all ones is in practice never reached.
- R8: A read of the status word returns the flags and then clears both of them; the flags otherwise stay set.
- R9: `irq_o` is high exactly when (alarm flag AND mode bit 16) OR (step flag AND mode bit 17).
- R10: Each rising edge of `slow_clk_i` is counted exactly once, provided its high and low phases each last at least three bus clock cycles, whatever their length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_clk_i | input | 1 | Asynchronous slow time base |
| bus_sel_i | input | 1 | Register transfer this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with PRESC_W = 8 and CNT_W = 32. With an 8-bit prescaler the reset divider is 128 and the zero-means-maximum divider is 256 slow edges. Both the reset value of the field and the full-range divide case then fit in a short run. The full 32-bit counter and alarm widths are kept, so the all-ones alarm behaves as it does in the default build.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  typedef enum logic [1:0] {
    OFS_MODE   = 2'd0,
    OFS_ALARM  = 2'd1,
    OFS_VALUE  = 2'd2,
    OFS_STATUS = 2'd3
  } rtt_ofs_e;

  localparam int unsigned BUS_W       = 32;
  localparam int unsigned BIT_ALM_EN  = 16;
  localparam int unsigned BIT_STEP_EN = 17;
  localparam int unsigned BIT_RESTART = 18;
  localparam int unsigned BIT_ALM_F   = 0;
  localparam int unsigned BIT_STEP_F  = 1;
endpackage

// File: rtl/rtt_tick_sync.sv
module rtt_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic tick_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], async_i};
  end

  assign tick_o = chain_q[STAGES-1] & ~chain_q[STAGES];

  p_single_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/rtt_prescaler.sv
module rtt_prescaler #(
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          restart_i,
  input  logic [PW-1:0] div_i,
  output logic          wrap_o
);
  logic [PW-1:0] phase_q;
  logic [PW-1:0] last_phase;

  // div_i == 0 gives all ones here, i.e. a divide by 2^PW
  assign last_phase = div_i - PW'(1);
  assign wrap_o     = tick_i && !restart_i && (phase_q == last_phase);

  always_ff @(posedge clk) begin
    if (!rst_n || restart_i) phase_q <= '0;
    else if (tick_i)         phase_q <= wrap_o ? '0 : phase_q + PW'(1);
  end

  p_wrap_resets_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> phase_q == '0);
  p_restart_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> phase_q == '0);
  p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !restart_i |=> $stable(phase_q));
endmodule

// File: rtl/rtt_count_alarm.sv
module rtt_count_alarm #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          restart_i,
  input  logic [CW-1:0] alarm_i,
  output logic [CW-1:0] count_o,
  output logic          match_o
);
  logic [CW-1:0] count_q;
  logic [CW-1:0] count_nxt;

  assign count_nxt = count_q + CW'(1);
  assign match_o   = step_i && !restart_i && (count_nxt == alarm_i);
  assign count_o   = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart_i) count_q <= '0;
    else if (step_i)         count_q <= count_nxt;
  end

  p_step_plus_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !restart_i |=> count_q == $past(count_q) + CW'(1));
  p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> count_q == '0);
  p_no_step_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i && !restart_i |=> $stable(count_q));
endmodule

// File: rtl/rtt_timer.sv
module rtt_timer
  import rtt_pkg::*;
#(
  parameter int unsigned PRESC_W = 16,
  parameter int unsigned CNT_W   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_clk_i,
  input  logic        bus_sel_i,
  input  logic        bus_wr_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        irq_o
);
  localparam logic [PRESC_W-1:0] PRESC_RST = PRESC_W'(1) << (PRESC_W - 1);

  logic [PRESC_W-1:0] presc_q;
  logic               alm_en_q, step_en_q;
  logic [CNT_W-1:0]   alarm_q;
  logic               alm_flag_q, step_flag_q;
  logic               slow_tick, step, match;
  logic [CNT_W-1:0]   count;
  logic               wr_mode, wr_alarm, rd_status, restart;
  logic [BUS_W-1:0]   mode_word, rd_mux;
  logic               unused_wdata;

  assign wr_mode   = bus_sel_i && bus_wr_i && (bus_addr_i == OFS_MODE);
  assign wr_alarm  = bus_sel_i && bus_wr_i && (bus_addr_i == OFS_ALARM);
  assign rd_status = bus_sel_i && !bus_wr_i && (bus_addr_i == OFS_STATUS);
  assign restart   = wr_mode && bus_wdata_i[BIT_RESTART];
  assign unused_wdata = ^bus_wdata_i;

  rtt_tick_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(slow_clk_i), .tick_o(slow_tick)
  );

  rtt_prescaler #(.PW(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick_i(slow_tick), .restart_i(restart),
    .div_i(presc_q), .wrap_o(step)
  );

  rtt_count_alarm #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step_i(step), .restart_i(restart),
    .alarm_i(alarm_q), .count_o(count), .match_o(match)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q   <= PRESC_RST;
      alm_en_q  <= 1'b0;
      step_en_q <= 1'b0;
      alarm_q   <= '1;
    end else begin
      if (wr_mode) begin
        presc_q   <= bus_wdata_i[PRESC_W-1:0];
        alm_en_q  <= bus_wdata_i[BIT_ALM_EN];
        step_en_q <= bus_wdata_i[BIT_STEP_EN];
      end
      if (wr_alarm) alarm_q <= bus_wdata_i[CNT_W-1:0];
    end
  end

  // a new event in the cycle of a status read wins over the clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm_flag_q  <= 1'b0;
      step_flag_q <= 1'b0;
    end else begin
      alm_flag_q  <= match | (alm_flag_q  & ~rd_status);
      step_flag_q <= step  | (step_flag_q & ~rd_status);
    end
  end

  always_comb begin
    mode_word = '0;
    mode_word[PRESC_W-1:0]  = presc_q;
    mode_word[BIT_ALM_EN]   = alm_en_q;
    mode_word[BIT_STEP_EN]  = step_en_q;
    unique case (bus_addr_i)
      OFS_MODE:  rd_mux = mode_word;
      OFS_ALARM: rd_mux = BUS_W'(alarm_q);
      OFS_VALUE: rd_mux = BUS_W'(count);
      default: begin
        rd_mux = '0;
        rd_mux[BIT_ALM_F]  = alm_flag_q;
        rd_mux[BIT_STEP_F] = step_flag_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      bus_rdata_o <= '0;
    else if (bus_sel_i && !bus_wr_i) bus_rdata_o <= rd_mux;
  end

  assign irq_o = (alm_flag_q & alm_en_q) | (step_flag_q & step_en_q);

  p_alarm_at_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_flag_q) && $stable(alarm_q) |-> count == alarm_q);
  p_step_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(count) && count != '0 |-> step_flag_q);
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_flag_q && !rd_status |=> step_flag_q);
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status && !match |=> !alm_flag_q);
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !alm_flag_q && !step_flag_q |-> !irq_o);
endmodule

// File: tb/rtt_timer_test.sv
module rtt_timer_test;
  localparam int PW = 8;
  localparam int CW = 32;

  logic clk = 0, rst_n = 0, slow = 0;
  logic sel = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  logic [PW-1:0] m_presc = 8'h80, m_phase = 0;
  logic m_alm_en = 0, m_step_en = 0, m_almf = 0, m_stepf = 0;
  logic [31:0] m_alarm = 32'hFFFF_FFFF, m_cnt = 0;

  always #5 clk = ~clk;

  rtt_timer #(.PRESC_W(PW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .slow_clk_i(slow), .bus_sel_i(sel),
    .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] mode_exp();
    return {14'd0, m_step_en, m_alm_en, 8'd0, m_presc};
  endfunction

  function automatic logic irq_exp();
    return (m_almf & m_alm_en) | (m_stepf & m_step_en);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
    if (a == 2'd0) begin
      m_presc = d[PW-1:0]; m_alm_en = d[16]; m_step_en = d[17];
      if (d[18]) begin m_cnt = 0; m_phase = 0; end
    end else if (a == 2'd1) m_alarm = d;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    @(negedge clk); sel = 0; d = rdata;
    if (a == 2'd3) begin m_almf = 0; m_stepf = 0; end
  endtask

  task automatic pulses(int n, int hi = 3, int lo = 3);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow = 1;
      repeat (hi) @(negedge clk);
      slow = 0;
      repeat (lo) @(negedge clk);
      if (m_phase == m_presc - 8'd1) begin
        m_phase = 0; m_cnt = m_cnt + 1; m_stepf = 1;
        if (m_cnt == m_alarm) m_almf = 1;
      end else m_phase = m_phase + 8'd1;
    end
  endtask

  task automatic chk_rd(string tag, logic [1:0] a);
    logic [31:0] d, e;
    e = (a == 0) ? mode_exp() : (a == 1) ? m_alarm : (a == 2) ? m_cnt
        : {30'd0, m_stepf, m_almf};
    bus_rd(a, d);
    chk(tag, d, e);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int r;
    r = $urandom(32'd1234);
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    bus_rd(2'd0, d); chk("R1 mode", d, 32'h0000_0080);
    bus_rd(2'd1, d); chk("R1 alarm", d, 32'hFFFF_FFFF);
    bus_rd(2'd2, d); chk("R1 value", d, 32'd0);
    bus_rd(2'd3, d); chk("R1 status", d, 32'd0);
    // R2 readback
    bus_wr(2'd1, 32'h1234_5678); chk_rd("R2 alarm rb", 2'd1);
    bus_wr(2'd0, 32'h0003_0005); chk_rd("R2 mode rb", 2'd0);
    // R5 restart bit reads zero, loads prescaler
    bus_wr(2'd0, 32'h0004_0003);
    bus_rd(2'd0, d); chk("R5 restart bit clear", d, 32'h0000_0003);
    // R4 writes ignored
    pulses(4);
    bus_wr(2'd2, 32'hDEAD_BEEF); chk_rd("R4 value write", 2'd2);
    bus_wr(2'd3, 32'h0000_0003); chk_rd("R4 status write", 2'd3);
    // R3 divide by 3
    bus_wr(2'd0, 32'h0004_0003);
    pulses(2); bus_rd(2'd2, d); chk("R3 div3 before", d, 32'd0);
    pulses(1); bus_rd(2'd2, d); chk("R3 div3 after", d, 32'd1);
    // R6 and R8
    bus_rd(2'd3, d); chk("R6 step flag", d, 32'h2);
    bus_rd(2'd3, d); chk("R8 cleared by read", d, 32'h0);
    // R10 long phases count once
    pulses(3, 25, 17); chk_rd("R10 long phases", 2'd2);
    // R9 step interrupt
    bus_wr(2'd0, 32'h0002_0003);
    pulses(3); chk("R9 irq step", {31'd0, irq}, 32'd1);
    bus_rd(2'd3, d); chk("R9 irq after clear", {31'd0, irq}, 32'd0);
    // R7 alarm
    bus_wr(2'd1, m_cnt + 2);
    bus_wr(2'd0, 32'h0001_0002);
    pulses(3); chk_rd("R7 before match", 2'd3);
    pulses(1); chk("R7 alarm irq", {31'd0, irq}, 32'd1);
    chk_rd("R7 alarm flag", 2'd3);
    // R5 mid-phase restart clears phase
    bus_wr(2'd0, 32'h0000_0003); pulses(2);
    bus_wr(2'd0, 32'h0004_0003);
    chk_rd("R5 counter zero", 2'd2);
    pulses(2); bus_rd(2'd2, d); chk("R5 phase cleared", d, 32'd0);
    pulses(1); bus_rd(2'd2, d); chk("R5 phase cleared step", d, 32'd1);
    // R3 prescaler zero = 256
    bus_wr(2'd0, 32'h0004_0000);
    pulses(255); bus_rd(2'd2, d); chk("R3 div256 before", d, 32'd0);
    pulses(1);   bus_rd(2'd2, d); chk("R3 div256 after", d, 32'd1);
    // R7 all-ones alarm never reached in practice
    bus_wr(2'd1, 32'hFFFF_FFFF);
    // random mix
    for (int it = 0; it < 60; it++) begin
      case ($urandom_range(0, 4))
        0: pulses($urandom_range(0, 7));
        1: bus_wr(2'd0, {13'd0, ($urandom_range(0, 3) == 0), 1'($urandom),
                         1'($urandom), 8'd0, 8'($urandom_range(1, 4))});
        2: bus_wr(2'd1, m_cnt + $urandom_range(1, 3));
        3: chk_rd("R3 random value", 2'd2);
        default: begin
          chk("R9 random irq", {31'd0, irq}, {31'd0, irq_exp()});
          chk_rd("R6 R7 random status", 2'd3);
        end
      endcase
    end
    chk_rd("R2 final mode", 2'd0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule